// File: doc/BRIEF.md
# I2C Slave Bus-Event Monitor

This block is the front end of an I2C slave. It samples the SCL and SDA lines at a rate taken from the system clock and divided by a selectable prescale factor. From these samples it finds Start and Stop conditions. After each Start it shifts in the first byte, which is the address byte. It raises an interrupt when that byte is complete and, optionally, when a Stop is first recorded.

Firmware controls the block through a small register port:

- A configuration register holds the enable, the rate choice, the Stop interrupt enable and the choice between two pin pairs.
- A status register holds two sticky flags, which firmware clears by writing 1.
- A read-only register holds the captured address byte.

Top module: `i2cs_event_front`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. The configuration register (offset 0) has these fields: enable at bit 0, rate select at bits 3:2, Stop interrupt enable at bit 4 and pin select at bit 6. Bits 1, 5 and 7 always read 0.
- R2: The rate select chooses the prescale factor: 00 gives DIV_STD100, 01 gives DIV_FAST400 and 10 gives DIV_STD50. The reserved code 11 gives the same factor as 00. One bit takes 16 samples, so transfers timed at 16 samples per bit are received at every code.
- R3: SCL and SDA pass through two sample-rate flops. A Start is SDA going from 1 to 0 while SCL stays 1. A Stop is SDA going from 0 to 1 while SCL stays 1.
- R4: While enable is 0, the block is held in reset. The status register (offset 1) and the address register (offset 2) read 0.
- R5: While enable is 1, a write to the configuration register leaves pin select unchanged. When enable is 0, pin select takes the written value, even in the same write that sets enable. Pin select 0 watches `scl_pin0`/`sda_pin0`; pin select 1 watches `scl_pin1`/`sda_pin1`. The pair that is not selected has no effect.
- R6: Status bit 0 is set on each Stop and stays set until firmware clears it. A Stop raises an interrupt only when Stop interrupt enable is 1 and the bit goes from 0 to 1. While the bit is already 1, a further Stop raises no interrupt.
- R7: After a Start, the block shifts in 8 bits, most significant bit first, one on each SCL rising edge. It then stores the byte in the address register, sets status bit 1 and pulses `irq` for one cycle.
- R8: Enable is passed through a synchroniser to the system clock. If the block is enabled while SCL is 1 and SDA is 0, it sees a Start. If it is enabled while both lines are 1, it sees none.
- R9: Writing 1 to a status bit clears it. If a clear and a new event fall in the same cycle, the event wins and the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 config, 1 status, 2 address byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| scl_pin0 | input | 1 | SCL, pin pair 0 |
| sda_pin0 | input | 1 | SDA, pin pair 0 |
| scl_pin1 | input | 1 | SCL, pin pair 1 |
| sda_pin1 | input | 1 | SDA, pin pair 1 |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with prescale factors of 4, 2 and 6 in place of the 12 MHz defaults. This keeps one bit to a few dozen system clocks, so many whole transfers fit in a short run. The three factors are still distinct, so each rate code, including the reserved one, carries real traffic timed to its own sample rate. With two enable-synchroniser stages, the spurious Start on enable and the pin-select lock can both be reached with only a few writes.

// File: rtl/evf_pkg.sv
// Package: shared register offsets, field positions and the rate code type
// for the I2C slave bus-event monitor. No logic.
package evf_pkg;
    localparam logic [1:0] OFS_CFG  = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_ADDR = 2'd2;

    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_RATE_LSB = 2;
    localparam int CFG_SIE_BIT  = 4;
    localparam int CFG_PSEL_BIT = 6;

    typedef enum logic [1:0] {
        RATE_STD100 = 2'b00,
        RATE_FAST   = 2'b01,
        RATE_STD50  = 2'b10,
        RATE_RSVD   = 2'b11
    } rate_e;
endpackage

// File: rtl/evf_cfg_regs.sv
// Configuration register and enable synchroniser.
// Assumes: writes come one cycle at a time on clk. The pin-select field is
// written only while the stored enable is 0. The enable reaches the core
// through EN_STAGES flops.
module evf_cfg_regs
    import evf_pkg::*;
#(
    parameter int EN_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_cfg,
    input  logic [7:0] wdata,
    output logic       en_run,
    output rate_e      rate,
    output logic       stop_ie,
    output logic       psel,
    output logic [7:0] cfg_view
);
    logic                 en_q;
    logic [EN_STAGES-1:0] en_pipe;
    logic                 unused_wbits;

    assign unused_wbits = ^{wdata[7], wdata[5], wdata[1]};

    // Hold the register fields; pin select is locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rate    <= RATE_STD100;
            stop_ie <= 1'b0;
            psel    <= 1'b0;
        end else if (wr_cfg) begin
            en_q    <= wdata[CFG_EN_BIT];
            rate    <= rate_e'(wdata[CFG_RATE_LSB +: 2]);
            stop_ie <= wdata[CFG_SIE_BIT];
            if (!en_q) psel <= wdata[CFG_PSEL_BIT];
        end
    end

    // Carry the enable into the clock domain through a flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) en_pipe <= '0;
        else        en_pipe <= {en_pipe[EN_STAGES-2:0], en_q};
    end

    assign en_run   = en_pipe[EN_STAGES-1];
    assign cfg_view = {1'b0, psel, 1'b0, stop_ie, rate, 1'b0, en_q};

    // R5
    psel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(psel));
endmodule

// File: rtl/evf_sample_tick.sv
// Sample-enable generator: one tick every div system clocks. The divisor
// is chosen by the rate code; the reserved code uses the standard-100
// divisor. Assumes every divisor is at least 1.
module evf_sample_tick
    import evf_pkg::*;
#(
    parameter int DIV_STD100 = 8,
    parameter int DIV_FAST400 = 2,
    parameter int DIV_STD50  = 15
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  rate_e rate,
    output logic  tick
);
    localparam int DMAX = (DIV_STD100 > DIV_FAST400) ?
        ((DIV_STD100 > DIV_STD50) ? DIV_STD100 : DIV_STD50) :
        ((DIV_FAST400 > DIV_STD50) ? DIV_FAST400 : DIV_STD50);
    localparam int CW = $clog2(DMAX + 1);

    logic [CW-1:0] div_m1;
    logic [CW-1:0] cnt;

    // Select the terminal count for the active rate.
    always_comb begin
        case (rate)
            RATE_FAST:  div_m1 = CW'(DIV_FAST400 - 1);
            RATE_STD50: div_m1 = CW'(DIV_STD50 - 1);
            default:    div_m1 = CW'(DIV_STD100 - 1);
        endcase
    end

    // Count system clocks between sample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    cnt <= '0;
        else if (cnt >= div_m1) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt >= div_m1);
endmodule

// File: rtl/evf_line_watch.sv
// Line synchroniser and condition detector. SCL and SDA are shifted through
// two flops on each sample tick, plus one flop that holds the previous
// synced sample. All flops reset to 1, the idle level of the bus, so a
// block enabled with SCL 1 and SDA 0 sees a Start.
module evf_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic sda_smp
);
    logic [2:0] scl_s;
    logic [2:0] sda_s;

    // Shift the lines through the synchroniser at the sample rate.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            scl_s <= 3'b111;
            sda_s <= 3'b111;
        end else if (tick) begin
            scl_s <= {scl_s[1:0], scl_in};
            sda_s <= {sda_s[1:0], sda_in};
        end
    end

    assign start_det = tick && scl_s[1] && scl_s[2] && sda_s[2] && !sda_s[1];
    assign stop_det  = tick && scl_s[1] && scl_s[2] && !sda_s[2] && sda_s[1];
    assign scl_rise  = tick && scl_s[1] && !scl_s[2];
    assign sda_smp   = sda_s[1];
endmodule

// File: rtl/evf_addr_grab.sv
// Address-byte receiver. After a Start it shifts in BITS bits, MSB first,
// on SCL rising edges, then stores the byte and pulses done. A Stop ends
// reception; a repeated Start restarts it. Cleared while not running.
module evf_addr_grab #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            scl_rise,
    input  logic            sda_smp,
    output logic            done,
    output logic [BITS-1:0] byte_q
);
    localparam int CNTW = $clog2(BITS);

    logic            busy;
    logic [CNTW-1:0] cnt;
    logic [BITS-1:0] shreg;

    // Track reception state and shift bits in on SCL rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy   <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            byte_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_det) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (stop_det) begin
                busy <= 1'b0;
            end else if (busy && scl_rise) begin
                shreg <= {shreg[BITS-2:0], sda_smp};
                if (cnt == CNTW'(BITS - 1)) begin
                    byte_q <= {shreg[BITS-2:0], sda_smp};
                    done   <= 1'b1;
                    busy   <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R7
    done_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(scl_rise));
endmodule

// File: rtl/i2cs_event_front.sv
// Top of the I2C slave bus-event monitor. Connects the configuration
// registers, the sample-tick generator, the line watcher and the address
// receiver. Holds the sticky status flags and drives the interrupt pulse.
// Assumes: reg_rdata is combinational on reg_addr.
module i2cs_event_front
    import evf_pkg::*;
#(
    parameter int DIV_STD100 = 8,
    parameter int DIV_FAST400 = 2,
    parameter int DIV_STD50  = 15,
    parameter int EN_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_pin0,
    input  logic       sda_pin0,
    input  logic       scl_pin1,
    input  logic       sda_pin1,
    output logic       irq
);
    logic       en_run, stop_ie, psel, tick;
    rate_e      rate;
    logic [7:0] cfg_view, addr_byte;
    logic       start_det, stop_det, scl_rise, sda_smp, addr_done;
    logic       stop_flag, addr_flag, wr_stat;

    evf_cfg_regs #(.EN_STAGES(EN_STAGES)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_cfg(reg_wr && reg_addr == OFS_CFG), .wdata(reg_wdata),
        .en_run(en_run), .rate(rate), .stop_ie(stop_ie), .psel(psel),
        .cfg_view(cfg_view)
    );

    evf_sample_tick #(.DIV_STD100(DIV_STD100), .DIV_FAST400(DIV_FAST400),
                      .DIV_STD50(DIV_STD50)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(en_run), .rate(rate), .tick(tick)
    );

    evf_line_watch u_line (
        .clk(clk), .rst_n(rst_n), .run(en_run), .tick(tick),
        .scl_in(psel ? scl_pin1 : scl_pin0),
        .sda_in(psel ? sda_pin1 : sda_pin0),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .sda_smp(sda_smp)
    );

    evf_addr_grab #(.BITS(8)) u_addr (
        .clk(clk), .rst_n(rst_n), .run(en_run),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .sda_smp(sda_smp),
        .done(addr_done), .byte_q(addr_byte)
    );

    assign wr_stat = reg_wr && reg_addr == OFS_STAT;

    // Sticky status flags: an event sets, a write of 1 clears, the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_run) begin
            stop_flag <= 1'b0;
            addr_flag <= 1'b0;
        end else begin
            if (stop_det)                  stop_flag <= 1'b1;
            else if (wr_stat && reg_wdata[0]) stop_flag <= 1'b0;
            if (addr_done)                 addr_flag <= 1'b1;
            else if (wr_stat && reg_wdata[1]) addr_flag <= 1'b0;
        end
    end

    // Interrupt pulse: address byte done, or a Stop that newly sets the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_run) irq <= 1'b0;
        else irq <= addr_done || (stop_det && !stop_flag && stop_ie);
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_CFG:  reg_rdata = cfg_view;
            OFS_STAT: reg_rdata = {6'b0, addr_flag, stop_flag};
            OFS_ADDR: reg_rdata = addr_byte;
            default:  reg_rdata = 8'h00;
        endcase
    end

    // R4
    clear_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_run |=> (!stop_flag && !addr_flag && !irq));
    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> stop_flag);
    // R6
    stop_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(addr_done)) |-> (stop_flag && !$past(stop_flag)));
endmodule

// File: tb/sim_i2cs_event_front.sv
// Bench: directed corner cases plus seeded random transfers. Drives inputs
// and samples outputs on the falling clock edge.
module sim_i2cs_event_front;
    localparam int CLK_PERIOD = 10;
    localparam int P100 = 4;
    localparam int P400 = 2;
    localparam int P50  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl0 = 1'b1, sda0 = 1'b1, scl1 = 1'b1, sda1 = 1'b1;
    logic       irq;
    logic       use1 = 1'b0;
    int         n_total = 0, n_fail = 0, irq_cnt = 0, hp = 32;
    logic       finished = 1'b0;
    logic [7:0] cfg_shadow = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cs_event_front #(.DIV_STD100(P100), .DIV_FAST400(P400),
                       .DIV_STD50(P50), .EN_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_pin0(scl0), .sda_pin0(sda0), .scl_pin1(scl1), .sda_pin1(sda1),
        .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    function automatic int half_of(input logic [1:0] r);
        case (r)
            2'b01:   return 8 * P400;
            2'b10:   return 8 * P50;
            default: return 8 * P100;
        endcase
    endfunction

    function automatic logic [7:0] exp_cfg(input logic [7:0] old, input logic [7:0] w);
        logic [7:0] n;
        n = w & 8'h5D;
        if (old[0]) n[6] = old[6];
        return n;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) cfg_shadow = exp_cfg(cfg_shadow, d);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic lines(input logic c, input logic d);
        if (use1) begin scl1 = c; sda1 = d; end
        else      begin scl0 = c; sda0 = d; end
    endtask

    task automatic bits8(input logic [7:0] b);
        logic cur;
        cur = use1 ? sda1 : sda0;
        for (int i = 7; i >= 0; i--) begin
            lines(1'b0, cur); cyc(hp);
            cur = b[i];
            lines(1'b0, cur); cyc(hp);
            lines(1'b1, cur); cyc(hp);
        end
        lines(1'b0, cur); cyc(hp);
    endtask

    task automatic stop_cond();
        lines(1'b0, 1'b0); cyc(hp);
        lines(1'b1, 1'b0); cyc(hp);
        lines(1'b1, 1'b1); cyc(4 * hp);
    endtask

    task automatic xfer(input logic [7:0] b);
        lines(1'b1, 1'b0); cyc(hp);
        bits8(b);
        stop_cond();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int base, seed;
        seed = $urandom(32'd1357);
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        rd(2'd0, v); check("R1 cfg reset", v, 8'h00);
        rd(2'd1, v); check("R1 status reset", v, 8'h00);
        rd(2'd2, v); check("R1 addr reset", v, 8'h00);
        check("R1 irq reset", irq, 1'b0);
        // R1 field positions and unused bits, block disabled
        wr(2'd0, 8'hBE); rd(2'd0, v); check("R1 cfg fields", v, exp_cfg(8'h00, 8'hBE));
        wr(2'd0, 8'h00);
        // R5 pin select set together with enable
        wr(2'd0, 8'h41); rd(2'd0, v); check("R5 psel with enable", v, 8'h41);
        // R5 pin select locked while enabled
        wr(2'd0, 8'h01); rd(2'd0, v); check("R5 psel locked", v, 8'h41);
        // R5 traffic on pair 0 ignored, pair 1 received
        hp = half_of(2'b00); cyc(4);
        use1 = 1'b0; base = irq_cnt; xfer(8'h5A);
        rd(2'd1, v); check("R5 unselected pair status", v, 8'h00);
        check("R5 unselected pair irq", irq_cnt - base, 0);
        use1 = 1'b1; base = irq_cnt; xfer(8'hC3);
        rd(2'd2, v); check("R5 selected pair addr", v, 8'hC3);
        rd(2'd1, v); check("R5 selected pair status", v, 8'h03);
        check("R7 irq on address", irq_cnt - base, 1);
        // R4 disable clears status and address
        wr(2'd0, 8'h00); cyc(4);
        rd(2'd1, v); check("R4 status cleared", v, 8'h00);
        rd(2'd2, v); check("R4 addr cleared", v, 8'h00);
        wr(2'd0, 8'h00); rd(2'd0, v); check("R5 psel free when off", v[6], 1'b0);
        use1 = 1'b0;
        // R6 sticky Stop: two Stops without clearing give one Stop irq
        wr(2'd0, 8'h11); cyc(4); base = irq_cnt;
        xfer(8'h12); xfer(8'h34);
        check("R6 one stop irq while sticky", irq_cnt - base, 3);
        rd(2'd1, v); check("R6 stop flag sticky", v[0], 1'b1);
        // R9 write-one clear
        wr(2'd1, 8'h01); rd(2'd1, v); check("R9 clear stop only", v, 8'h02);
        wr(2'd1, 8'h02); rd(2'd1, v); check("R9 clear addr", v, 8'h00);
        base = irq_cnt; xfer(8'h77);
        check("R6 stop irq after clear", irq_cnt - base, 2);
        // R6 Stop interrupt disabled still sets flag
        wr(2'd0, 8'h01); wr(2'd1, 8'h03); base = irq_cnt; xfer(8'h81);
        check("R6 no stop irq when disabled", irq_cnt - base, 1);
        rd(2'd1, v); check("R6 flag without irq", v, 8'h03);
        // R8 enable with SCL high and SDA low gives a false Start
        wr(2'd0, 8'h00); lines(1'b1, 1'b0); cyc(4);
        wr(2'd0, 8'h01); cyc(4 * hp); base = irq_cnt;
        bits8(8'hA5); stop_cond();
        rd(2'd2, v); check("R8 false start captures", v, 8'hA5);
        check("R8 false start irq", irq_cnt - base, 1);
        // R8 enable with idle bus: no Start, no capture
        wr(2'd0, 8'h00); lines(1'b1, 1'b1); cyc(4);
        wr(2'd0, 8'h01); cyc(4 * hp); base = irq_cnt;
        bits8(8'h3C); stop_cond();
        rd(2'd1, v); check("R8 idle enable status", v, 8'h01);
        rd(2'd2, v); check("R8 idle enable addr", v, 8'h00);
        check("R3 stop without start irq", irq_cnt - base, 0);
        // R2 R3 R7 random transfers across all rate codes
        for (int k = 0; k < 8; k++) begin
            logic [1:0] r;
            logic [7:0] a;
            logic sie;
            r = 2'(k % 4); a = 8'($urandom); sie = 1'($urandom);
            wr(2'd0, {3'b000, sie, r, 2'b01});
            wr(2'd1, 8'h03);
            hp = half_of(r); cyc(4);
            base = irq_cnt; xfer(a);
            rd(2'd2, v); check($sformatf("R2 R7 rate %0d addr", r), v, a);
            rd(2'd1, v); check("R3 R7 status", v, 8'h03);
            check("R6 R7 irq count", irq_cnt - base, sie ? 2 : 1);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule